// File: doc/BRIEF.md
# Video Memory Contention Clock Gate

This block sits between a free-running CPU clock source and an 8-bit processor. It decides, on every rising edge of the source clock, whether the processor clock must be frozen. The processor shares one 16 KB RAM window with a video fetch engine. A memory cycle that targets that window while the engine is in one of its fetch slots is stalled by keeping the processor clock in its high phase. Every other access runs at full speed. This covers ROM at the bottom of the map, all of the upper half of the map, I/O cycles, and an alternate bank paged over the window.

The video engine supplies two signals: a flag that marks active display time, and a phase number within its repeating 8-clock pattern. The first six phases of the pattern are fetch slots and the last two are free. The stall decision is made once, at the clock edge where a memory cycle begins. A stalled cycle is released at the first edge that samples a free slot, and after that it runs to completion without a second stall. The block also has a contention flag and a saturating count of stretched clock periods.

Top module: `vid_contention_gate`

## Requirements
- R1: A synchronous active-low reset clears the contention flag and the stretch count. While reset is low, the processor clock follows the source clock, and this holds even when reset arrives in the middle of a stall.
- R2: A memory cycle whose address has bit 15 set (0x8000 to 0xFFFF) is never stalled, whatever the video phase.
- R3: A memory cycle to the ROM region 0x0000 to 0x3FFF is never stalled.
- R4: A memory cycle that starts at an edge sampling an address in 0x4000 to 0x7FFF, with `vid_active` high, `page_alt` low and `vid_phase` below 6, is stalled. During the stall the processor clock stays high and `contended` is 1.
- R5: A stall that starts with phase p (p < 6) is released at the first edge that samples phase 6, so it lasts exactly 6 − p source clock periods.
- R6: A shared-window cycle that starts while phase is 6 or 7 (a free slot) is not stalled.
- R7: With `vid_active` low, no shared-window cycle is stalled.
- R8: With `page_alt` high (an alternate bank paged over the shared window), shared-window cycles are not stalled.
- R9: Only memory requests (`mreq_n` low with `iorq_n` high) can be stalled. An I/O request, or a bus with no request, never stalls.
- R10: The stall decision is made only at the edge where a memory cycle starts. A cycle that was released, or that began unstalled, is not stalled again by later fetch slots while `mreq_n` stays low.
- R11: `stretch_cnt` rises by exactly one for each stretched source clock period, holds otherwise, and saturates at its all-ones value.
- R12: The gated clock is glitch-free. It enters the held state only during a high phase, and on release it falls at the next normal falling edge. In every low phase of the source clock, `cpu_clk` equals `contended`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock for the processor |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| vid_active | input | 1 | Video engine is in active display time |
| vid_phase | input | 3 | Position within the 8-clock fetch pattern |
| page_alt | input | 1 | Alternate bank is paged over the shared window |
| cpu_clk | output | 1 | Gated clock to the processor |
| contended | output | 1 | A stall is in progress |
| stretch_cnt | output | 16 | Saturating count of stretched clock periods |

## Verification
The stall length depends on which phase of the fetch pattern the cycle starts in. The bench therefore drives the video phase itself and holds each request back until the phase that the next rising edge will sample equals the value the vector asks for. This covers every entry phase, including the last fetch slot and both free slots. The hardest case is a cycle that stays in progress after its release while a new run of fetch slots arrives (R10). Each request is kept asserted for twelve clocks, so every vector spans a full second fetch window after its decision edge, and any re-stall shows up both in the held-clock tally and in the stretch count. The bench reaches saturation by repeating full-length stalls on a narrow counter.

// File: rtl/vcg_pkg.sv
// Package: shared types for the video contention clock gate.
// Assumes: a single clock domain (the source clock) for all state.
package vcg_pkg;

    // Memory-cycle tracking state of the stall controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no memory cycle in progress
        ST_HOLD = 2'd1,   // cycle stalled, processor clock held high
        ST_BUSY = 2'd2    // cycle in progress, decided, not stalled
    } stall_st_t;

endpackage

// File: rtl/vcg_addr_decode.sv
// Module: vcg_addr_decode
// Flags a memory request that falls inside the window shared with the
// video engine and that really reaches the home bank there.
// Assumes: the window is one contiguous range [WIN_BASE, WIN_LAST]. When
// an alternate bank is paged over it, the video engine still reads the
// home bank, so those accesses do not collide.
module vcg_addr_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'h7FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              page_alt,
    output logic              candidate
);

    logic in_window;

    // Range compare over the full address width.
    always_comb begin
        in_window = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        candidate = mem_req && in_window && !page_alt;
    end

endmodule

// File: rtl/vcg_slot_timer.sv
// Module: vcg_slot_timer
// Tells whether the video engine is using the shared window at this
// edge. The first FETCH_SLOTS phases of each pattern are fetch slots and
// the rest are free.
// Assumes: vid_phase is supplied by the video engine and advances once
// per source clock.
module vcg_slot_timer #(
    parameter int unsigned PHASE_W     = 3,
    parameter int unsigned FETCH_SLOTS = 6
) (
    input  logic               vid_active,
    input  logic [PHASE_W-1:0] vid_phase,
    output logic               fetch_busy
);

    localparam int unsigned PATTERN_LEN = 1 << PHASE_W;

    generate
        if (FETCH_SLOTS >= PATTERN_LEN) begin : g_all_slots
            // Every phase fetches: busy for the whole active period.
            always_comb fetch_busy = vid_active && (vid_phase == vid_phase);
        end else begin : g_partial_slots
            // Busy only in the leading fetch phases.
            always_comb fetch_busy = vid_active && (32'(vid_phase) < FETCH_SLOTS);
        end
    endgenerate

endmodule

// File: rtl/vcg_stall_fsm.sv
// Module: vcg_stall_fsm
// Tracks processor memory cycles and decides, once at the edge where a
// cycle starts, whether it must be stalled. Releases the stall at the
// first edge that samples a free slot.
// Assumes: the processor keeps mem_req asserted for the whole cycle, and
// a new cycle is marked by mem_req going from low to high.
module vcg_stall_fsm
    import vcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req,
    input  logic candidate,
    input  logic fetch_busy,
    output logic hold
);

    stall_st_t state_q;
    stall_st_t state_d;

    // Next-state decision for the cycle tracker.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mem_req) begin
                    state_d = (candidate && fetch_busy) ? ST_HOLD : ST_BUSY;
                end
            end
            ST_HOLD: begin
                if (!fetch_busy) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (!mem_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // The hold flag comes straight from a register, so it changes only at rising edges.
    always_comb hold = (state_q == ST_HOLD);

endmodule

// File: rtl/vcg_stretch_counter.sv
// Module: vcg_stretch_counter
// Counts source clock periods in which the processor clock was held.
// Saturates at all ones rather than wrapping.
// Assumes: hold is a registered signal in the same clock domain.
module vcg_stretch_counter #(
    parameter int unsigned COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    output logic [COUNT_W-1:0] count
);

    localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

    // Saturating increment for each held period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (hold && (count != COUNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/vid_contention_gate.sv
// Module: vid_contention_gate
// Gates the processor clock when a memory cycle to the shared video
// window collides with a video fetch slot. The clock is held in its high
// phase for the length of the stall.
// Assumes: rst_n is synchronous to clk_src. The hold flag is registered
// on the rising edge, so it only changes while clk_src is already high.
// ORing it into the clock therefore gives neither a glitch nor a runt
// pulse.
module vid_contention_gate #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned PHASE_W     = 3,
    parameter int unsigned FETCH_SLOTS = 6,
    parameter int unsigned COUNT_W     = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'h7FFF
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               mreq_n,
    input  logic               iorq_n,
    input  logic               vid_active,
    input  logic [PHASE_W-1:0] vid_phase,
    input  logic               page_alt,
    output logic               cpu_clk,
    output logic               contended,
    output logic [COUNT_W-1:0] stretch_cnt
);

    logic mem_req;
    logic candidate;
    logic fetch_busy;
    logic hold;

    // Only a memory request (not an I/O request) can reach the RAM.
    always_comb mem_req = !mreq_n && iorq_n;

    vcg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST)
    ) i_decode (
        .addr      (addr),
        .mem_req   (mem_req),
        .page_alt  (page_alt),
        .candidate (candidate)
    );

    vcg_slot_timer #(
        .PHASE_W     (PHASE_W),
        .FETCH_SLOTS (FETCH_SLOTS)
    ) i_slots (
        .vid_active (vid_active),
        .vid_phase  (vid_phase),
        .fetch_busy (fetch_busy)
    );

    vcg_stall_fsm i_fsm (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .mem_req    (mem_req),
        .candidate  (candidate),
        .fetch_busy (fetch_busy),
        .hold       (hold)
    );

    vcg_stretch_counter #(
        .COUNT_W (COUNT_W)
    ) i_count (
        .clk   (clk_src),
        .rst_n (rst_n),
        .hold  (hold),
        .count (stretch_cnt)
    );

    // Clock stretch: force the processor clock high while holding.
    always_comb begin
        cpu_clk   = clk_src | hold;
        contended = hold;
    end

endmodule

// File: rtl/vcg_checker.sv
// Module: vcg_checker
// Temporal checks on the contention gate, attached with bind.
// Assumes: the same parameters as the gate it is bound to.
module vcg_checker #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned PHASE_W     = 3,
    parameter int unsigned FETCH_SLOTS = 6,
    parameter int unsigned COUNT_W     = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'h7FFF
) (
    input logic               clk_src,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               mreq_n,
    input logic               iorq_n,
    input logic               vid_active,
    input logic [PHASE_W-1:0] vid_phase,
    input logic               page_alt,
    input logic               contended,
    input logic [COUNT_W-1:0] stretch_cnt
);

    localparam logic [COUNT_W-1:0] CNT_TOP = '1;
    localparam logic [ADDR_W-1:0]  UPPER_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

    logic slot_fetch;
    logic win_hit;

    // Reference view of the fetch slot and the shared window.
    always_comb begin
        slot_fetch = vid_active && (32'(vid_phase) < FETCH_SLOTS);
        win_hit    = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk_src)
        !rst_n |=> (!contended && stretch_cnt == '0));

    // R4
    stall_cause_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(contended) |-> $past(!mreq_n && iorq_n && win_hit && !page_alt && slot_fetch));

    // R2
    upper_half_free_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!mreq_n && addr >= UPPER_BASE && !contended) |=> !contended);

    // R8
    paged_bank_free_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!mreq_n && page_alt && !contended) |=> !contended);

    // R5
    release_on_free_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (contended && !slot_fetch) |=> !contended);

    // R11
    count_step_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (contended && stretch_cnt != CNT_TOP) |=> stretch_cnt == $past(stretch_cnt) + 1'b1);

    // R11
    count_still_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        !contended |=> $stable(stretch_cnt));

endmodule

bind vid_contention_gate vcg_checker #(
    .ADDR_W      (ADDR_W),
    .PHASE_W     (PHASE_W),
    .FETCH_SLOTS (FETCH_SLOTS),
    .COUNT_W     (COUNT_W),
    .WIN_BASE    (WIN_BASE),
    .WIN_LAST    (WIN_LAST)
) i_vcg_checker (
    .clk_src     (clk_src),
    .rst_n       (rst_n),
    .addr        (addr),
    .mreq_n      (mreq_n),
    .iorq_n      (iorq_n),
    .vid_active  (vid_active),
    .vid_phase   (vid_phase),
    .page_alt    (page_alt),
    .contended   (contended),
    .stretch_cnt (stretch_cnt)
);

// File: tb/test_vid_contention_gate.sv
`timescale 1ns/1ps
// Bench for vid_contention_gate. A vector table is walked first, then
// directed tests cover saturation and reset during a stall.
module test_vid_contention_gate;

    localparam int unsigned CW = 5;
    localparam logic [CW-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [15:0] addr;
        logic        mreq_n;
        logic        iorq_n;
        logic        vact;
        logic        palt;
        logic [2:0]  phase;
        logic [2:0]  stall;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{16'h4000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd6},
        '{16'h5A5A, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3, 3'd3},
        '{16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5, 3'd1},
        '{16'h6000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd6, 3'd0},
        '{16'h4100, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0},
        '{16'h8000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0},
        '{16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 3'd0},
        '{16'hC123, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 3'd0},
        '{16'h3FFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0},
        '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 3'd0},
        '{16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0},
        '{16'h4000, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0},
        '{16'h4000, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
        '{16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0}
    };

    logic          clk_src = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   addr = '0;
    logic          mreq_n = 1'b1;
    logic          iorq_n = 1'b1;
    logic          vid_active = 1'b0;
    logic [2:0]    vid_phase = '0;
    logic          page_alt = 1'b0;
    logic          cpu_clk;
    logic          contended;
    logic [CW-1:0] stretch_cnt;

    int checks = 0;
    int errors = 0;
    int held = 0;
    int glitch = 0;
    bit finished = 1'b0;

    always #2.5 clk_src = ~clk_src;

    vid_contention_gate #(.COUNT_W(CW)) i_vid_contention_gate (
        .clk_src     (clk_src),
        .rst_n       (rst_n),
        .addr        (addr),
        .mreq_n      (mreq_n),
        .iorq_n      (iorq_n),
        .vid_active  (vid_active),
        .vid_phase   (vid_phase),
        .page_alt    (page_alt),
        .cpu_clk     (cpu_clk),
        .contended   (contended),
        .stretch_cnt (stretch_cnt)
    );

    // Requirement tag covered by each table row.
    function automatic string vec_tag(input int idx);
        case (idx)
            0:       return "R4";
            1, 2:    return "R5";
            3:       return "R6";
            4:       return "R10";
            5, 6, 7: return "R2";
            8, 9:    return "R3";
            10:      return "R7";
            11:      return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One source clock: sample in the low phase, then advance the video phase.
    task automatic step();
        @(negedge clk_src);
        if (cpu_clk === 1'b1) held++;
        if (rst_n && (cpu_clk !== contended)) glitch++;
        vid_phase = vid_phase + 3'd1;
    endtask

    task automatic bus_idle();
        mreq_n = 1'b1;
        iorq_n = 1'b1;
    endtask

    // Start a memory cycle so that the next rising edge samples phase ph.
    task automatic launch(input logic [15:0] a, input logic mq, input logic iq,
                          input logic va, input logic pa, input logic [2:0] ph);
        step();
        step();
        while (vid_phase != ph) step();
        addr       = a;
        mreq_n     = mq;
        iorq_n     = iq;
        vid_active = va;
        page_alt   = pa;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int expc;
        // R1: reset state
        rst_n = 1'b0;
        step();
        step();
        check(contended === 1'b0, "R1", "contended in reset", int'(contended), 0);
        check(stretch_cnt === '0, "R1", "count in reset", int'(stretch_cnt), 0);
        check(cpu_clk === 1'b0, "R1", "clock low phase in reset", int'(cpu_clk), 0);
        rst_n = 1'b1;
        step();

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            launch(VECS[i].addr, VECS[i].mreq_n, VECS[i].iorq_n,
                   VECS[i].vact, VECS[i].palt, VECS[i].phase);
            c0 = int'(stretch_cnt);
            held = 0;
            glitch = 0;
            repeat (12) step();
            check(held == int'(VECS[i].stall), vec_tag(i), "held periods",
                  held, int'(VECS[i].stall));
            // R11: count follows stretched periods
            check(int'(stretch_cnt) - c0 == int'(VECS[i].stall), "R11", "count delta",
                  int'(stretch_cnt) - c0, int'(VECS[i].stall));
            // R12: clock equals the flag in every low phase
            check(glitch == 0, "R12", "low-phase clock mismatches", glitch, 0);
            bus_idle();
            step();
            step();
            check(contended === 1'b0, vec_tag(i), "flag after cycle", int'(contended), 0);
        end

        // R11: saturation with full-length stalls
        for (int k = 0; k < 4; k++) begin
            expc = int'(stretch_cnt) + 6;
            if (expc > int'(CNT_TOP)) expc = int'(CNT_TOP);
            launch(16'h4400, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0);
            repeat (10) step();
            bus_idle();
            step();
            check(int'(stretch_cnt) == expc, "R11", "saturating count",
                  int'(stretch_cnt), expc);
        end
        step();
        check(stretch_cnt === CNT_TOP, "R11", "stays saturated", int'(stretch_cnt), int'(CNT_TOP));

        // R1: reset in the middle of a stall
        launch(16'h4800, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1);
        step();
        step();
        check(contended === 1'b1, "R4", "stall under way", int'(contended), 1);
        rst_n = 1'b0;
        step();
        check(contended === 1'b0, "R1", "flag after mid-stall reset", int'(contended), 0);
        check(cpu_clk === 1'b0, "R1", "clock released by reset", int'(cpu_clk), 0);
        check(stretch_cnt === '0, "R1", "count after mid-stall reset", int'(stretch_cnt), 0);
        bus_idle();
        rst_n = 1'b1;
        step();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule